// File: doc/BRIEF.md
# Two-Input Pair Sequence Set/Clear/Toggle Latch

This block watches two serial data bits, sampled together as a pair on every rising clock edge, and holds a single registered flag. The flag is changed only when the pair sampled on the current edge completes one of three two-step patterns that began with the pair sampled on the edge before. Every other pattern leaves the flag alone.

The three patterns work as follows. A "falling" pair (first bit 1, second bit 0) followed by both bits high forces the flag to 1. A "rising" pair (first bit 0, second bit 1) followed by both bits high forces it to 0. A falling pair followed by a rising pair inverts it. The pairs 00 and 11 start no pattern, so they are folded into one "flat" history class. The state therefore holds only the history class (flat, rising or falling) and the current flag value, which gives six states. The flag is a Moore output taken straight from the state register.

Top module: `pair_seq_latch`

## Requirements
- R1: A synchronous active-high reset puts the flag at 0 and the history class at flat, so the first pair after reset starts no pattern, even if the pair applied during reset was 10.
- R2: A pair 01 (bit_a=0, bit_b=1) followed on the next edge by the pair 11 drives z_out to 0.
- R3: A pair 10 (bit_a=1, bit_b=0) followed on the next edge by the pair 11 drives z_out to 1.
- R4: A pair 10 followed on the next edge by the pair 01 inverts z_out.
- R5: Every other pair-to-pair sequence leaves z_out unchanged, including 11 after 11, 01 after 01, 10 after 10, and any pair after 00.
- R6: The pairs 00 and 11 share one history class: a rising or falling pair separated from a later 11 by a 00 (or by a further 11) does not clear or set the flag.
- R7: z_out is registered: it changes only after the clock edge that samples the pair completing a pattern, and a change on bit_a or bit_b between edges has no effect on it.
- R8: The pair 01 that completes an inversion also opens a clear pattern, so 10, 01, 11 inverts the flag on the second edge and clears it on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; the input pair is sampled here |
| rst | input | 1 | Synchronous active-high reset |
| bit_a | input | 1 | First bit of the input pair |
| bit_b | input | 1 | Second bit of the input pair |
| z_out | output | 1 | Registered flag |

## Verification
The interesting coincidence is a single pair that closes one pattern and opens the next in the same cycle: the rising pair 01 ends an inversion and starts a clear, and the falling pair 10 always starts either a set or an inversion while the previous pair may have been the second half of nothing. The bench drives 10, 01, 11 back to back and expects the flag to invert on the middle edge and fall to 0 on the last one, and it repeats this inside a long run of random pairs where a behavioural model that keeps the raw previous pair predicts the flag after every edge. Each result is also checked between edges to confirm the new pair has not yet reached the output.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;

    localparam int PAIR_W = 2;

    // History class of the previous pair; 00 and 11 fold into FLAT.
    typedef enum logic [1:0] {
        CLS_FLAT = 2'd0,
        CLS_RISE = 2'd1,   // pair 01
        CLS_FALL = 2'd2    // pair 10
    } pair_cls_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_SET   = 2'd2,
        ACT_FLIP  = 2'd3
    } z_action_e;

    typedef struct packed {
        pair_cls_e prev;
        logic      z;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{prev: CLS_FLAT, z: 1'b0};

    // pair[1] is bit_a, pair[0] is bit_b.
    function automatic pair_cls_e classify(input logic [PAIR_W-1:0] pair);
        pair_cls_e c;
        unique case (pair)
            2'b01:   c = CLS_RISE;
            2'b10:   c = CLS_FALL;
            default: c = CLS_FLAT;
        endcase
        return c;
    endfunction

    function automatic z_action_e pick_action(input pair_cls_e prev,
                                              input logic [PAIR_W-1:0] pair);
        z_action_e act;
        act = ACT_HOLD;
        if (pair == 2'b11) begin
            if (prev == CLS_RISE)      act = ACT_CLEAR;
            else if (prev == CLS_FALL) act = ACT_SET;
        end else if (pair == 2'b01 && prev == CLS_FALL) begin
            act = ACT_FLIP;
        end
        return act;
    endfunction

    function automatic logic apply_action(input z_action_e act, input logic z);
        logic r;
        unique case (act)
            ACT_CLEAR: r = 1'b0;
            ACT_SET:   r = 1'b1;
            ACT_FLIP:  r = ~z;
            default:   r = z;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pair_seq_classify.sv
module pair_seq_classify
    import pair_seq_pkg::*;
(
    input  logic [PAIR_W-1:0] pair,
    output pair_cls_e         cls
);

    always_comb begin
        cls = classify(pair);
    end

    // R6: both-equal pairs never produce a rising or falling class
    always_comb begin
        if (pair[1] == pair[0]) begin
            a_flat_fold_r6: assert (cls == CLS_FLAT)
                else $error("equal pair not classed flat");
        end
    end

endmodule

// File: rtl/pair_seq_decide.sv
module pair_seq_decide
    import pair_seq_pkg::*;
(
    input  seq_state_t        cur_state,
    input  logic [PAIR_W-1:0] pair,
    input  pair_cls_e         cls,
    output z_action_e         act,
    output seq_state_t        next_state
);

    always_comb begin
        act             = pick_action(cur_state.prev, pair);
        next_state.prev = cls;
        next_state.z    = apply_action(act, cur_state.z);
    end

    // R4: an inversion can only be chosen when the new class is rising
    always_comb begin
        if (act == ACT_FLIP) begin
            a_flip_class_r4: assert (cls == CLS_RISE)
                else $error("flip chosen with class %0d", cls);
        end
    end

endmodule

// File: rtl/pair_seq_state.sv
module pair_seq_state
    import pair_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t next_state,
    output seq_state_t state
);

    always_ff @(posedge clk) begin
        if (rst) state <= RESET_STATE;
        else     state <= next_state;
    end

    // R1: the cycle after reset the register holds flat history and flag 0
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (state.prev == CLS_FLAT && state.z == 1'b0));

    // legal encodings only
    p_class_legal_r5: assert property (@(posedge clk) disable iff (rst)
        state.prev != 2'd3);

endmodule

// File: rtl/pair_seq_latch.sv
module pair_seq_latch
    import pair_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_a,
    input  logic bit_b,
    output logic z_out
);

    logic [PAIR_W-1:0] pair;
    pair_cls_e         cls;
    z_action_e         act;
    seq_state_t        state;
    seq_state_t        next_state;

    assign pair  = {bit_a, bit_b};
    assign z_out = state.z;

    pair_seq_classify u_classify (
        .pair (pair),
        .cls  (cls)
    );

    pair_seq_decide u_decide (
        .cur_state  (state),
        .pair       (pair),
        .cls        (cls),
        .act        (act),
        .next_state (next_state)
    );

    pair_seq_state u_state (
        .clk        (clk),
        .rst        (rst),
        .next_state (next_state),
        .state      (state)
    );

    // R2: rising history then 11 clears the flag
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (state.prev == CLS_RISE && bit_a && bit_b) |=> !z_out);

    // R3: falling history then 11 sets the flag
    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (state.prev == CLS_FALL && bit_a && bit_b) |=> z_out);

    // R4: falling history then 01 inverts the flag
    p_flip_r4: assert property (@(posedge clk) disable iff (rst)
        (state.prev == CLS_FALL && !bit_a && bit_b) |=> (z_out != $past(z_out)));

    // R5: no pattern completed, flag holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !((state.prev == CLS_RISE && bit_a && bit_b) ||
          (state.prev == CLS_FALL && bit_b)) |=> $stable(z_out));

    // R6: a flat pair always leaves flat history behind
    p_flat_history_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_a == bit_b) |=> (state.prev == CLS_FLAT));

endmodule

// File: tb/pair_seq_latch_bench.sv
`timescale 1ns/1ps
module pair_seq_latch_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_a = 1'b0;
    logic bit_b = 1'b0;
    logic z_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model: raw previous pair and expected flag
    int ref_prev = 0;
    int ref_z    = 0;

    always #10 clk = ~clk;   // 50 MHz

    pair_seq_latch u_pair_seq_latch (
        .clk   (clk),
        .rst   (rst),
        .bit_a (bit_a),
        .bit_b (bit_b),
        .z_out (z_out)
    );

    task automatic check(input logic got, input int exp, input string tag);
        n_run++;
        if (got !== exp[0]) begin
            n_fail++;
            $display("FAIL %s: z_out=%0b expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        rst = 1'b1; bit_a = a; bit_b = b;
        @(posedge clk);
        @(posedge clk);
        #2;
        ref_z = 0; ref_prev = 0;
        check(z_out, 0, "R1 reset value");
    endtask

    task automatic step(input logic a, input logic b, input string note);
        int cur;
        int nz;
        string tag;
        @(negedge clk);
        rst = 1'b0; bit_a = a; bit_b = b;
        #1;
        check(z_out, ref_z, "R7 no effect before edge");
        cur = {30'd0, a, b};
        nz  = ref_z;
        if (ref_prev == 1 && cur == 3) begin
            nz = 0; tag = "R2 clear";
        end else if (ref_prev == 2 && cur == 3) begin
            nz = 1; tag = "R3 set";
        end else if (ref_prev == 2 && cur == 1) begin
            nz = 1 - ref_z; tag = "R4 invert";
        end else if (ref_prev == 0 || ref_prev == 3) begin
            tag = "R6 flat history hold";
        end else begin
            tag = "R5 hold";
        end
        @(posedge clk);
        #2;
        ref_z = nz; ref_prev = cur;
        check(z_out, ref_z, {tag, note});
    endtask

    initial begin
        do_reset(1'b0, 1'b0);
        step(0, 0, "");
        step(1, 0, "");
        step(1, 1, "");          // set -> 1
        step(0, 1, "");
        step(1, 1, "");          // clear -> 0
        step(1, 0, "");
        step(0, 1, " R8");       // invert -> 1, opens clear
        step(1, 1, " R8");       // clear -> 0
        step(1, 0, "");
        step(0, 1, "");          // invert -> 1
        step(1, 0, "");
        step(0, 1, "");          // invert -> 0
        step(1, 0, "");
        step(1, 1, "");          // set -> 1
        step(0, 1, "");
        step(0, 0, "");
        step(1, 1, "");          // R6: stays 1
        step(0, 1, "");
        step(1, 1, "");          // clear -> 0
        step(1, 0, "");
        step(0, 0, "");
        step(1, 1, "");          // R6: stays 0
        step(1, 0, "");
        step(1, 1, "");          // set -> 1
        step(1, 1, "");          // R5 hold
        step(0, 1, "");
        step(0, 1, "");          // R5 hold
        step(1, 0, "");
        step(1, 0, "");
        step(1, 1, "");          // set
        // R1: reset with 10 applied must forget the falling history
        step(1, 0, "");
        do_reset(1'b1, 1'b0);
        step(0, 1, " R1 history cleared");
        step(1, 1, "");
        for (int i = 0; i < 400; i++) begin
            logic [1:0] r;
            r = 2'($urandom_range(0, 3));
            step(r[1], r[0], " random");
            if (i == 200) do_reset(r[1], r[0]);
        end
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule